// File: doc/BRIEF.md
# Two-Axis Shifting SAD Array

This block is the arithmetic core of a block-matching motion search. It holds a 16x16 window of reference pixels and a 16x16 block of current pixels in registers, and on command it forms the absolute difference of every co-located pixel pair. That is 256 differences in one cycle. Each row's differences are summed in groups of four neighbouring pixels, which gives 64 partial sums. These are registered and presented together one cycle later.

The reference window is never written at a random address. It moves. A vertical step pushes a freshly fetched 16-pixel row in at the bottom and drops the top row. A horizontal step pushes one new pixel into the right end of every row and drops the leftmost pixel. A search controller can therefore walk a candidate position across the search area while fetching only one row or one column per step. The current block is written a row at a time through an addressed 128-bit port.

Combining the partials into block-size sums and choosing the search order are left to logic outside the block.

Top module: `sad_shift_array`

## Requirements
- R1: After a synchronous active-low reset, `sad_valid` is 0, every partial sum is 0, and every stored reference and current pixel is 0. A compute issued right after reset therefore returns all zeros.
- R2: A current-row write (`cur_we`) replaces only row `cur_row_sel` of the current block with `cur_row_data`. Pixel j of a row occupies bits [8j+7:8j]. All other rows keep their contents.
- R3: A vertical step (`ref_vshift`) moves reference row r+1 into row r for rows 0 to 14 and loads `ref_row_data` into row 15. The old row 0 is discarded.
- R4: A horizontal step (`ref_hshift`) moves pixel j+1 into pixel j of every reference row and loads `ref_col_data[8r+7:8r]` into pixel 15 of row r. The old pixel 0 of each row is discarded.
- R5: A compute (`sad_go`) produces, for row r and group g, the value sum over k=0..3 of |ref[r][4g+k] - cur[r][4g+k]|. The result is placed at `sad_partials[(4r+g)*10 +: 10]` and uses the pixel contents present in the cycle of the command.
- R6: `sad_valid` is 1 in exactly the cycle after an accepted compute. Between accepted computes, `sad_partials` holds its last value.
- R7: When several commands are raised in one cycle, only one is accepted, in the priority order `cur_we`, `ref_vshift`, `ref_hshift`, `sad_go`. The others have no effect on storage or outputs.
- R8: A partial sum reaches 1020 (four differences of 255) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_we | input | 1 | Write one row of the current block |
| cur_row_sel | input | 4 | Row index for the current-row write |
| cur_row_data | input | 128 | Sixteen 8-bit current pixels |
| ref_vshift | input | 1 | Vertical step of the reference window |
| ref_row_data | input | 128 | New bottom reference row |
| ref_hshift | input | 1 | Horizontal step of the reference window |
| ref_col_data | input | 128 | New right-edge pixel for each of the 16 rows |
| sad_go | input | 1 | Compute partial sums at the present position |
| sad_valid | output | 1 | Partial sums updated in the previous cycle |
| sad_partials | output | 640 | 64 partial sums of 10 bits, row-major with group fastest |

## Verification
The array is first run with random pixel pairs, which exercise the magnitude-and-sign handling of every difference in both orders. It is then run with runs of horizontal and vertical steps between computes, which separate a correct shift direction and fill position from an off-by-one or mirrored one. A single-row rewrite followed by a compute shows whether a write reaches neighbouring rows. An all-255 against all-0 pattern checks the top of the sum range. Commands raised together check the priority order: the reference model ignores the lower commands, and the compared outputs show whether the design did the same.

// File: rtl/sad_pkg.sv
// Shared command encoding for the SAD array.
// Assumes: the top decodes its four command strobes into one op per cycle.
package sad_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_CUR  = 3'd1,
        OP_VSH  = 3'd2,
        OP_HSH  = 3'd3,
        OP_SAD  = 3'd4
    } sad_op_e;

    // Picks the single accepted command; loads win, compute is lowest.
    function automatic sad_op_e pick_op(input logic cur, input logic vsh,
                                        input logic hsh, input logic go);
        if (cur)      return OP_CUR;
        else if (vsh) return OP_VSH;
        else if (hsh) return OP_HSH;
        else if (go)  return OP_SAD;
        else          return OP_IDLE;
    endfunction

endpackage

// File: rtl/sad_ref_window.sv
// Reference pixel window: rows shift up on a vertical step, pixels shift
// left on a horizontal step. All rows are exposed in parallel.
// Assumes: at most one of vsh_en / hsh_en is high in a cycle.
module sad_ref_window #(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int PIX_W = 8,
    localparam int ROW_W = COLS * PIX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vsh_en,
    input  logic [ROW_W-1:0]        row_in,
    input  logic                    hsh_en,
    input  logic [ROWS*PIX_W-1:0]   col_in,
    output logic [ROW_W-1:0]        rows_out [ROWS]
);

    logic [ROW_W-1:0] win_q [ROWS];

    // Per-row storage update: vertical, horizontal or hold.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[r] <= '0;
            end else if (vsh_en) begin
                if (r == ROWS - 1) win_q[r] <= row_in;
                else               win_q[r] <= win_q[(r + 1) % ROWS];
            end else if (hsh_en) begin
                win_q[r] <= {col_in[r*PIX_W +: PIX_W], win_q[r][ROW_W-1:PIX_W]};
            end
        end

        assign rows_out[r] = win_q[r];

        // R4: the rightmost pixel of each row takes that row's column input.
        p_col_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hsh_en |=> win_q[r][ROW_W-1 -: PIX_W] == $past(col_in[r*PIX_W +: PIX_W]));

        // R7: no step means the row is untouched.
        p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!vsh_en && !hsh_en) |=> $stable(win_q[r]));
    end

    // R3: the bottom row takes the new row and the top row takes the old second row.
    p_bottom_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsh_en |=> win_q[ROWS-1] == $past(row_in));
    p_rows_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsh_en |=> win_q[0] == $past(win_q[1]));

    // R7: the decoder never issues both steps together.
    p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsh_en && hsh_en));

endmodule

// File: rtl/sad_cur_bank.sv
// Current block storage, written one addressed row at a time.
// Assumes: sel is below ROWS whenever we is high.
module sad_cur_bank #(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int PIX_W = 8,
    localparam int ROW_W = COLS * PIX_W,
    localparam int SEL_W = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [ROW_W-1:0]   wdata,
    output logic [ROW_W-1:0]   rows_out [ROWS]
);

    logic [ROW_W-1:0] bank_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row register: written only when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                   bank_q[r] <= '0;
            else if (we && sel == SEL_W'(r)) bank_q[r] <= wdata;
        end

        assign rows_out[r] = bank_q[r];

        // R2: the addressed row takes the data and every other row holds.
        p_row_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_W'(r)) |=> bank_q[r] == $past(wdata));
        p_row_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == SEL_W'(r)) |=> $stable(bank_q[r]));
    end

endmodule

// File: rtl/sad_row_unit.sv
// One row of absolute-difference logic: GRP_N groups of GRP_PIX pixels,
// each reduced by an adder tree to one partial sum. Purely combinational.
// Assumes: SUM_W is wide enough for GRP_PIX maximum differences.
module sad_row_unit #(
    parameter int COLS    = 16,
    parameter int PIX_W   = 8,
    parameter int GRP_PIX = 4,
    parameter int SUM_W   = 10,
    localparam int ROW_W  = COLS * PIX_W,
    localparam int GRP_N  = COLS / GRP_PIX
) (
    input  logic [ROW_W-1:0]        ref_row,
    input  logic [ROW_W-1:0]        cur_row,
    output logic [GRP_N*SUM_W-1:0]  partials
);

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        logic [SUM_W-1:0] acc;

        // Absolute differences of one pixel group, added together.
        always_comb begin
            acc = '0;
            for (int k = 0; k < GRP_PIX; k++) begin
                logic [PIX_W-1:0] a, b;
                a = ref_row[(g*GRP_PIX + k)*PIX_W +: PIX_W];
                b = cur_row[(g*GRP_PIX + k)*PIX_W +: PIX_W];
                acc = acc + SUM_W'((a > b) ? (a - b) : (b - a));
            end
        end

        assign partials[g*SUM_W +: SUM_W] = acc;
    end

endmodule

// File: rtl/sad_shift_array.sv
// Top of the SAD array: decodes the command strobes by priority, holds the
// reference window and current block, and registers all partial sums.
// Assumes: the caller keeps pixel data valid in the cycle of its strobe.
module sad_shift_array
    import sad_pkg::*;
#(
    parameter int ROWS    = 16,
    parameter int COLS    = 16,
    parameter int PIX_W   = 8,
    parameter int GRP_PIX = 4,
    localparam int ROW_W  = COLS * PIX_W,
    localparam int SEL_W  = $clog2(ROWS),
    localparam int GRP_N  = COLS / GRP_PIX,
    localparam int SUM_W  = PIX_W + $clog2(GRP_PIX),
    localparam int OUT_W  = ROWS * GRP_N * SUM_W,
    localparam int MAX_SUM = GRP_PIX * ((1 << PIX_W) - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_we,
    input  logic [SEL_W-1:0]   cur_row_sel,
    input  logic [ROW_W-1:0]   cur_row_data,
    input  logic               ref_vshift,
    input  logic [ROW_W-1:0]   ref_row_data,
    input  logic               ref_hshift,
    input  logic [ROWS*PIX_W-1:0] ref_col_data,
    input  logic               sad_go,
    output logic               sad_valid,
    output logic [OUT_W-1:0]   sad_partials
);

    sad_op_e          op;
    logic [ROW_W-1:0] ref_rows [ROWS];
    logic [ROW_W-1:0] cur_rows [ROWS];
    logic [OUT_W-1:0] sad_next;
    logic [OUT_W-1:0] sad_q;
    logic             valid_q;

    // One accepted command per cycle, loads first.
    assign op = pick_op(cur_we, ref_vshift, ref_hshift, sad_go);

    sad_ref_window #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsh_en   (op == OP_VSH),
        .row_in   (ref_row_data),
        .hsh_en   (op == OP_HSH),
        .col_in   (ref_col_data),
        .rows_out (ref_rows)
    );

    sad_cur_bank #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (op == OP_CUR),
        .sel      (cur_row_sel),
        .wdata    (cur_row_data),
        .rows_out (cur_rows)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_rows
        sad_row_unit #(.COLS(COLS), .PIX_W(PIX_W), .GRP_PIX(GRP_PIX), .SUM_W(SUM_W)) u_row (
            .ref_row  (ref_rows[r]),
            .cur_row  (cur_rows[r]),
            .partials (sad_next[r*GRP_N*SUM_W +: GRP_N*SUM_W])
        );
    end

    // Output register: capture sums on compute, pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sad_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (op == OP_SAD);
            if (op == OP_SAD) sad_q <= sad_next;
        end
    end

    assign sad_valid    = valid_q;
    assign sad_partials = sad_q;

    // R6: an unblocked compute yields valid on the next cycle.
    p_go_to_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sad_go && !cur_we && !ref_vshift && !ref_hshift) |=> sad_valid);

    // R7: valid only ever follows a compute that no load or step blocked.
    p_valid_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> $past(sad_go && !cur_we && !ref_vshift && !ref_hshift));

    // R6: outputs hold whenever no fresh result is flagged.
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sad_valid |-> $stable(sad_partials));

    // R8: no partial exceeds the largest possible four-pixel sum.
    for (genvar f = 0; f < ROWS * GRP_N; f++) begin : g_bound
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            sad_partials[f*SUM_W +: SUM_W] <= SUM_W'(MAX_SUM));
    end

endmodule

// File: tb/sad_shift_array_bench.sv
// Bench: behavioural model of windows and sums, compared every cycle.
module sad_shift_array_bench;

    localparam int N = 16;
    localparam int SW = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cur_we = 1'b0;
    logic [3:0]   cur_row_sel = '0;
    logic [127:0] cur_row_data = '0;
    logic         ref_vshift = 1'b0;
    logic [127:0] ref_row_data = '0;
    logic         ref_hshift = 1'b0;
    logic [127:0] ref_col_data = '0;
    logic         sad_go = 1'b0;
    logic         sad_valid;
    logic [639:0] sad_partials;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int refm [N][N];
    int curm [N][N];
    int expm [N][4];
    bit exp_valid;

    always #5 clk = ~clk;

    sad_shift_array u_sad_shift_array (
        .clk(clk), .rst_n(rst_n),
        .cur_we(cur_we), .cur_row_sel(cur_row_sel), .cur_row_data(cur_row_data),
        .ref_vshift(ref_vshift), .ref_row_data(ref_row_data),
        .ref_hshift(ref_hshift), .ref_col_data(ref_col_data),
        .sad_go(sad_go), .sad_valid(sad_valid), .sad_partials(sad_partials)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin refm[r][c] = 0; curm[r][c] = 0; end
            for (int g = 0; g < 4; g++) expm[r][g] = 0;
        end
        exp_valid = 0;
    endtask

    // Model of one clock edge with the inputs present now.
    task automatic model_edge();
        exp_valid = 0;
        if (cur_we) begin
            for (int c = 0; c < N; c++) curm[cur_row_sel][c] = int'(cur_row_data[c*8 +: 8]);
        end else if (ref_vshift) begin
            for (int r = 0; r < N - 1; r++)
                for (int c = 0; c < N; c++) refm[r][c] = refm[r+1][c];
            for (int c = 0; c < N; c++) refm[N-1][c] = int'(ref_row_data[c*8 +: 8]);
        end else if (ref_hshift) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N - 1; c++) refm[r][c] = refm[r][c+1];
                refm[r][N-1] = int'(ref_col_data[r*8 +: 8]);
            end
        end else if (sad_go) begin
            for (int r = 0; r < N; r++)
                for (int g = 0; g < 4; g++) begin
                    int s = 0;
                    for (int k = 0; k < 4; k++) s += iabs(refm[r][4*g+k] - curm[r][4*g+k]);
                    expm[r][g] = s;
                end
            exp_valid = 1;
        end
    endtask

    task automatic compare(input string req);
        bit bad = 0;
        string msg = "";
        checks++;
        if (sad_valid !== exp_valid) begin
            bad = 1;
            msg = $sformatf("valid actual=%0b expected=%0b", sad_valid, exp_valid);
        end else begin
            for (int r = 0; r < N && !bad; r++)
                for (int g = 0; g < 4 && !bad; g++)
                    if (int'(sad_partials[(4*r+g)*SW +: SW]) != expm[r][g]) begin
                        bad = 1;
                        msg = $sformatf("row %0d group %0d actual=%0d expected=%0d",
                                        r, g, sad_partials[(4*r+g)*SW +: SW], expm[r][g]);
                    end
        end
        if (bad) begin
            errors++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Apply the current inputs for one cycle, then check at the next falling edge.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cur_we = 0; ref_vshift = 0; ref_hshift = 0; sad_go = 0;
        compare(req);
    endtask

    task automatic do_compute(input string req);
        sad_go = 1; step(req);
        step(req);
    endtask

    task automatic random_row(output logic [127:0] v);
        for (int c = 0; c < N; c++) v[c*8 +: 8] = 8'($urandom_range(0, 255));
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1");
        do_compute("R1");

        // R2: fill the current block with random rows.
        for (int r = 0; r < N; r++) begin
            cur_we = 1; cur_row_sel = 4'(r); random_row(cur_row_data); step("R2");
        end
        // R3: fill the reference window by vertical steps.
        for (int r = 0; r < N; r++) begin
            ref_vshift = 1; random_row(ref_row_data); step("R3");
        end
        do_compute("R5");

        // R4: horizontal walk with a compute after each step.
        for (int i = 0; i < 5; i++) begin
            ref_hshift = 1; random_row(ref_col_data); step("R4");
            do_compute("R4");
        end
        // R3: vertical walk.
        for (int i = 0; i < 3; i++) begin
            ref_vshift = 1; random_row(ref_row_data); step("R3");
            do_compute("R3");
        end

        // R2: rewrite one row only.
        cur_we = 1; cur_row_sel = 4'd7; cur_row_data = '0; step("R2");
        do_compute("R2");

        // R7: conflicting commands, one winner each.
        cur_we = 1; cur_row_sel = 4'd3; random_row(cur_row_data); sad_go = 1; step("R7");
        ref_vshift = 1; ref_hshift = 1; random_row(ref_row_data); random_row(ref_col_data); step("R7");
        ref_hshift = 1; sad_go = 1; random_row(ref_col_data); step("R7");
        cur_we = 1; ref_vshift = 1; cur_row_sel = 4'd9; random_row(cur_row_data);
        random_row(ref_row_data); step("R7");
        do_compute("R7");

        // R8: full-scale difference in every pixel.
        for (int r = 0; r < N; r++) begin
            cur_we = 1; cur_row_sel = 4'(r); cur_row_data = '0; step("R8");
        end
        for (int r = 0; r < N; r++) begin
            ref_vshift = 1; ref_row_data = '1; step("R8");
        end
        do_compute("R8");

        // R6: outputs hold across idle cycles.
        repeat (4) step("R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule